// File: doc/BRIEF.md
# Paged Memory Window Mapper

This block sits between a processor with a 20-bit segmented address and its paged memory. Four 64 KB windows, at segments 0x6, 0x7, 0x8 and 0x9, each hold their own 8-bit page number. The two lower windows reach RAM and the two upper windows reach ROM. Software sets the page numbers through a small register write port. For a RAM window the block turns the page and offset into a physical word address, one of four RAM chip selects, an extra high column bit and the two byte-lane strobes. For a ROM window it gives a ROM select and the ROM page number.

The installed RAM population is a static configuration input. Smaller populations fold the page number, so several page numbers reach the same memory. A page that has no RAM behind it raises a "no memory" flag instead of a chip select. The decode is purely combinational from the current address and the registered page numbers. A register write therefore affects accesses from the next clock cycle onward.

Top module: `pgwin_mapper`

## Requirements
- R1: On reset all four page registers read as 0x00. Reset takes effect at once when `rst_n` falls and is released on the second rising clock edge after `rst_n` rises.
- R2: When `reg_we` is high at a rising edge, `reg_wdata` is loaded into the page register picked by `reg_sel` (0 and 1 are the RAM windows, 2 and 3 are the ROM windows). The new value applies to accesses after that edge and not before. When `reg_we` is low, no register changes.
- R3: Address bits [19:16] pick the window. Segment 0x6 uses page register 0 and segment 0x7 uses register 1, both as RAM. Segment 0x8 uses register 2 and segment 0x9 uses register 3, both as ROM. For a ROM window `rom_sel` is 1, `rom_page` equals the page register, and no RAM output is active.
- R4: For any other segment, no chip select, no byte lane, no ROM select and no `ram_nomem` is asserted, and `rom_page` and `ram_addr` read 0.
- R5: At most one bit of `ram_cs` is high. The chip select number is bits [6:5] of the folded page, so each select covers 32 pages (2 MB).
- R6: `ram_size` = 0 (512 KB): pages with bits [6:5] = 00 are valid, and the folded page is bits [2:0] only. For example 0x03, 0x0B, 0x13 and 0x1B all reach the same memory through select 0.
- R7: `ram_size` = 1 (1 MB): pages with bit 6 = 0 are valid. The folded page is {bit 5, 00, bits [2:0]}, so pages 0x20–0x3F alias modulo 8 on select 1.
- R8: `ram_size` = 2 (2 MB): only pages 0x00–0x1F are valid. `ram_size` = 3 (4 MB): pages 0x00–0x3F are valid. In both cases there is no folding.
- R9: Page bit 7 takes no part in validity or chip select. On a RAM hit it appears as `ram_col_hi`, which is otherwise 0.
- R10: A RAM window access to a page that is not valid for the size sets `ram_nomem`, and leaves every chip select and both lanes low.
- R11: On a RAM hit, a word access (`byte_acc` = 0) sets both lanes. A byte access at an even offset sets only `ram_lb`, and at an odd offset sets only `ram_ub`.
- R12: On a RAM hit, `ram_addr` = {folded page[6:0], offset[15:1]}. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Page register write strobe |
| reg_sel | input | 2 | Page register number |
| reg_wdata | input | 8 | Page value to write |
| cpu_addr | input | 20 | Segmented CPU address |
| byte_acc | input | 1 | 1 = byte access, 0 = word access |
| ram_size | input | 2 | Installed RAM: 0=512K, 1=1M, 2=2M, 3=4M |
| ram_cs | output | 4 | RAM chip selects |
| ram_addr | output | 22 | Physical RAM word address |
| ram_col_hi | output | 1 | Extra high column bit (page bit 7) |
| ram_ub | output | 1 | Upper byte lane select |
| ram_lb | output | 1 | Lower byte lane select |
| ram_nomem | output | 1 | RAM window hit an unpopulated page |
| rom_sel | output | 1 | ROM window access |
| rom_page | output | 8 | ROM page number |

## Verification
The hardest case to reach from the ports is the exact cycle in which a new page value starts to apply. The write and the access must overlap, and the output is sampled both before and after the loading edge. The bench drives a write to one RAM window while that same window is being addressed. It checks that the old page is still visible before the edge and the new one after it, and that the other RAM window is left unchanged. The aliasing and unpopulated-page cases are reached by reprogramming the page register and the size input for each table vector. Pages with bit 7 set are included, so that folding, validity and the column bit are exercised together.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  typedef enum logic [1:0] {
    SZ_512K = 2'd0,
    SZ_1M   = 2'd1,
    SZ_2M   = 2'd2,
    SZ_4M   = 2'd3
  } ram_size_e;

  localparam int NUM_WIN = 4;
  localparam int WSEL_W  = 2;
endpackage

// File: rtl/pgwin_regs.sv
module pgwin_regs #(
  parameter int NUM_WIN = 4,
  parameter int PAGE_W  = 8,
  localparam int SEL_W  = $clog2(NUM_WIN)
) (
  input  logic                            clk,
  input  logic                            rst_n_s,
  input  logic                            we,
  input  logic [SEL_W-1:0]                sel,
  input  logic [PAGE_W-1:0]               wdata,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]  pages
);
  logic [NUM_WIN-1:0][PAGE_W-1:0] page_q, page_d;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_reg
    always_comb begin
      page_d[i] = page_q[i];
      if (we && (sel == SEL_W'(i))) page_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) page_q[i] <= '0;
      else          page_q[i] <= page_d[i];
    end
  end

  assign pages = page_q;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    we |=> (page_q[$past(sel)] == $past(wdata)));
  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !we |=> $stable(page_q));
endmodule

// File: rtl/pgwin_fold.sv
module pgwin_fold
  import pgwin_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int CS_N    = 4,
  parameter int ALIAS_W = 3,
  localparam int FP_W      = PAGE_W - 1,
  localparam int CS_IDX_W  = $clog2(CS_N),
  localparam int CHIP_PG_W = FP_W - CS_IDX_W
) (
  input  ram_size_e            size,
  input  logic [FP_W-1:0]      page_lo,
  output logic                 valid,
  output logic [FP_W-1:0]      folded,
  output logic [CS_IDX_W-1:0]  cs_idx
);
  always_comb begin
    folded = '0;
    valid  = 1'b0;
    unique case (size)
      SZ_512K: begin
        valid                  = (page_lo[FP_W-1:CHIP_PG_W] == '0);
        folded[ALIAS_W-1:0]    = page_lo[ALIAS_W-1:0];
      end
      SZ_1M: begin
        valid                  = (page_lo[FP_W-1:CHIP_PG_W+1] == '0);
        folded[CHIP_PG_W]      = page_lo[CHIP_PG_W];
        folded[ALIAS_W-1:0]    = page_lo[ALIAS_W-1:0];
      end
      SZ_2M: begin
        valid  = (page_lo[FP_W-1:CHIP_PG_W] == '0);
        folded = page_lo;
      end
      SZ_4M: begin
        valid  = (page_lo[FP_W-1:CHIP_PG_W+1] == '0);
        folded = page_lo;
      end
      default: begin
        valid  = 1'b0;
        folded = '0;
      end
    endcase
  end

  assign cs_idx = folded[FP_W-1:CHIP_PG_W];
endmodule

// File: rtl/pgwin_lane.sv
module pgwin_lane (
  input  logic hit,
  input  logic byte_acc,
  input  logic a0,
  output logic ub,
  output logic lb
);
  always_comb begin
    ub = hit && (!byte_acc || a0);
    lb = hit && (!byte_acc || !a0);
  end
endmodule

// File: rtl/pgwin_mapper.sv
module pgwin_mapper
  import pgwin_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int OFF_W    = 16,
  parameter int PAGE_W   = 8,
  parameter int CS_N     = 4,
  parameter int SEG_BASE = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [1:0]                 reg_sel,
  input  logic [PAGE_W-1:0]          reg_wdata,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic                       byte_acc,
  input  logic [1:0]                 ram_size,
  output logic [CS_N-1:0]            ram_cs,
  output logic [PAGE_W+OFF_W-3:0]    ram_addr,
  output logic                       ram_col_hi,
  output logic                       ram_ub,
  output logic                       ram_lb,
  output logic                       ram_nomem,
  output logic                       rom_sel,
  output logic [PAGE_W-1:0]          rom_page
);
  localparam int SEG_W    = ADDR_W - OFF_W;
  localparam int FP_W     = PAGE_W - 1;
  localparam int CS_IDX_W = $clog2(CS_N);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [NUM_WIN-1:0][PAGE_W-1:0] pages;

  pgwin_regs #(.NUM_WIN(NUM_WIN), .PAGE_W(PAGE_W)) u_regs (
    .clk     (clk),
    .rst_n_s (rst_n_s),
    .we      (reg_we),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .pages   (pages)
  );

  // window decode
  logic [SEG_W-1:0]  seg, win_diff;
  logic [OFF_W-1:0]  off;
  logic              in_win, is_ram, is_rom;
  logic [WSEL_W-1:0] win_idx;
  logic [PAGE_W-1:0] cur_page;

  always_comb begin
    seg      = cpu_addr[ADDR_W-1:OFF_W];
    off      = cpu_addr[OFF_W-1:0];
    win_diff = seg - SEG_W'(SEG_BASE);
    in_win   = (win_diff < SEG_W'(NUM_WIN));
    win_idx  = win_diff[WSEL_W-1:0];
    cur_page = pages[win_idx];
    is_ram   = in_win && !win_idx[1];
    is_rom   = in_win &&  win_idx[1];
  end

  logic                 pg_valid, ram_hit;
  logic [FP_W-1:0]      folded;
  logic [CS_IDX_W-1:0]  cs_idx;

  pgwin_fold #(.PAGE_W(PAGE_W), .CS_N(CS_N), .ALIAS_W(3)) u_fold (
    .size    (ram_size_e'(ram_size)),
    .page_lo (cur_page[FP_W-1:0]),
    .valid   (pg_valid),
    .folded  (folded),
    .cs_idx  (cs_idx)
  );

  assign ram_hit = is_ram && pg_valid;

  for (genvar c = 0; c < CS_N; c++) begin : g_cs
    assign ram_cs[c] = ram_hit && (cs_idx == CS_IDX_W'(c));
  end

  pgwin_lane u_lane (
    .hit      (ram_hit),
    .byte_acc (byte_acc),
    .a0       (off[0]),
    .ub       (ram_ub),
    .lb       (ram_lb)
  );

  always_comb begin
    ram_addr   = ram_hit ? {folded, off[OFF_W-1:1]} : '0;
    ram_col_hi = ram_hit && cur_page[PAGE_W-1];
    ram_nomem  = is_ram && !pg_valid;
    rom_sel    = is_rom;
    rom_page   = is_rom ? cur_page : '0;
  end

  assert_single_cs_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(ram_cs));
  assert_nomem_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    ram_nomem |-> (ram_cs == '0 && !ram_ub && !ram_lb));
  assert_rom_excludes_ram_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    rom_sel |-> (ram_cs == '0 && !ram_nomem && !ram_ub && !ram_lb));
  assert_outside_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_addr[ADDR_W-1:OFF_W] < SEG_W'(SEG_BASE) ||
     cpu_addr[ADDR_W-1:OFF_W] >= SEG_W'(SEG_BASE + NUM_WIN))
    |-> (ram_cs == '0 && !rom_sel && !ram_nomem));
  assert_lanes_need_cs_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ram_ub || ram_lb) |-> (ram_cs != '0));
endmodule

// File: tb/sim_pgwin_mapper.sv
module sim_pgwin_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic [19:0] cpu_addr;
  logic        byte_acc;
  logic [1:0]  ram_size;
  logic [3:0]  ram_cs;
  logic [21:0] ram_addr;
  logic        ram_col_hi, ram_ub, ram_lb, ram_nomem, rom_sel;
  logic [7:0]  rom_page;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pgwin_mapper u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cpu_addr(cpu_addr), .byte_acc(byte_acc),
    .ram_size(ram_size), .ram_cs(ram_cs), .ram_addr(ram_addr),
    .ram_col_hi(ram_col_hi), .ram_ub(ram_ub), .ram_lb(ram_lb),
    .ram_nomem(ram_nomem), .rom_sel(rom_sel), .rom_page(rom_page)
  );

  typedef struct packed {
    logic [1:0]  sz;
    logic [3:0]  seg;
    logic [7:0]  pg;
    logic [15:0] off;
    logic        byt;
    logic [3:0]  cs;
    logic        nomem;
    logic        rom;
    logic [7:0]  rpg;
    logic        col;
    logic        ub;
    logic        lb;
    logic [21:0] addr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 4'h6, 8'h05, 16'h1234, 1'b0, 4'b0001, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 22'h02891A},
    '{2'd0, 4'h6, 8'h1B, 16'h0001, 1'b1, 4'b0001, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 22'h018000},
    '{2'd0, 4'h7, 8'h13, 16'h0000, 1'b1, 4'b0001, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 22'h018000},
    '{2'd0, 4'h6, 8'h20, 16'h0000, 1'b0, 4'b0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 22'h000000},
    '{2'd1, 4'h7, 8'h2C, 16'hFFFE, 1'b0, 4'b0010, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 22'h127FFF},
    '{2'd1, 4'h6, 8'h44, 16'h0010, 1'b0, 4'b0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 22'h000000},
    '{2'd3, 4'h6, 8'h3F, 16'h8000, 1'b0, 4'b0010, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 22'h1FC000},
    '{2'd2, 4'h6, 8'h3F, 16'h8000, 1'b0, 4'b0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 22'h000000},
    '{2'd2, 4'h6, 8'h85, 16'h1234, 1'b0, 4'b0001, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 22'h02891A},
    '{2'd0, 4'h7, 8'hA0, 16'h0000, 1'b0, 4'b0000, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 22'h000000},
    '{2'd2, 4'h8, 8'h9A, 16'h4321, 1'b0, 4'b0000, 1'b0, 1'b1, 8'h9A, 1'b0, 1'b0, 1'b0, 22'h000000},
    '{2'd0, 4'h9, 8'h80, 16'h0001, 1'b1, 4'b0000, 1'b0, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 22'h000000},
    '{2'd2, 4'hA, 8'h11, 16'h0000, 1'b0, 4'b0000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 22'h000000},
    '{2'd2, 4'h5, 8'h11, 16'h0000, 1'b0, 4'b0000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 22'h000000},
    '{2'd3, 4'h6, 8'h1F, 16'h0003, 1'b1, 4'b0001, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 22'h0F8001}
  };

  string vtag [NV] = '{
    "R3 R5 R12", "R6 R11", "R6 R11 alias", "R6 R10", "R7 R5 R12", "R7 R10",
    "R8 R5 R12", "R8 R10", "R9 R12", "R9 R10", "R3 rom0", "R3 rom1",
    "R4 seg A", "R4 seg 5", "R11 R8"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    cpu_addr = 20'h60000; byte_acc = 1'b0; ram_size = 2'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #2;
    chk("R1 cs after reset", 32'(ram_cs), 32'h1);
    chk("R1 addr after reset", 32'(ram_addr), 32'h0);
    cpu_addr = 20'h80000; #2;
    chk("R1 rom page2 after reset", 32'(rom_page), 32'h0);
    cpu_addr = 20'h90000; #2;
    chk("R1 rom page3 after reset", 32'(rom_page), 32'h0);

    // R2 write timing on the window being accessed
    @(negedge clk);
    cpu_addr = 20'h70002; reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h07;
    #2;
    chk("R2 old page before edge", 32'(ram_addr), 32'h1);
    @(posedge clk); #2;
    chk("R2 new page after edge", 32'(ram_addr), 32'h38001);
    @(negedge clk);
    reg_we = 1'b0; cpu_addr = 20'h60002; #2;
    chk("R2 other window untouched", 32'(ram_addr), 32'h1);

    // R2 no write without strobe
    reg_sel = 2'd2; reg_wdata = 8'h55;
    @(negedge clk);
    cpu_addr = 20'h80000; #2;
    chk("R2 no write when strobe low", 32'(rom_page), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      ram_size = VEC[i].sz;
      if (VEC[i].seg >= 4'h6 && VEC[i].seg <= 4'h9) wr(2'(VEC[i].seg - 4'h6), VEC[i].pg);
      else                                           wr(2'd0, VEC[i].pg);
      cpu_addr = {VEC[i].seg, VEC[i].off};
      byte_acc = VEC[i].byt;
      #2;
      chk({vtag[i], " cs"},    32'(ram_cs),     32'(VEC[i].cs));
      chk({vtag[i], " nomem"}, 32'(ram_nomem),  32'(VEC[i].nomem));
      chk({vtag[i], " rom"},   32'(rom_sel),    32'(VEC[i].rom));
      chk({vtag[i], " rpage"}, 32'(rom_page),   32'(VEC[i].rpg));
      chk({vtag[i], " col"},   32'(ram_col_hi), 32'(VEC[i].col));
      chk({vtag[i], " lanes"}, {30'd0, ram_ub, ram_lb}, {30'd0, VEC[i].ub, VEC[i].lb});
      chk({vtag[i], " addr"},  32'(ram_addr),   32'(VEC[i].addr));
    end

    // R1 asynchronous reset clears a programmed register at once
    @(negedge clk);
    cpu_addr = 20'h90000; byte_acc = 1'b0; #2;
    chk("R1 rom page3 before reset", 32'(rom_page), 32'h80);
    rst_n = 1'b0; #2;
    chk("R1 async clear", 32'(rom_page), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule